// File: doc/BRIEF.md
# Enhanced Parallel Port Address/Data Cycle Engine

This block sits behind a parallel port's register bus and turns host accesses to the address register (offset 3) and the data register (offset 4) into byte-wide handshake cycles on the peripheral side. A cycle runs only when the stored control byte holds the one exact pattern that selects the wanted direction. Otherwise the access completes at once with no peripheral activity. Data accesses may be one, two or four bytes wide. Wider accesses run as a chain of byte cycles, lowest byte first, and the register bus stays busy until the whole chain ends.

Each byte cycle has two phases. In the first, the engine raises the address or data strobe and waits for the peripheral's wait line to rise. In the second, it drops the strobe and waits for wait to fall. A programmable limit bounds each phase. If the limit expires, the access is aborted, any bytes not yet moved are skipped, and a sticky timeout flag is set. The flag appears as bit 0 of a status register read (offset 1). A status write with bit 0 set clears it.

The controller has four states. ST_IDLE takes a request, then moves to ST_STROBE when the cycle is allowed ("start") or to ST_FINISH when it is not ("skip"). ST_STROBE moves to ST_RELEASE when wait rises ("ack") or to ST_FINISH when its limit expires ("ack-timeout"). ST_RELEASE, once wait falls, returns to ST_STROBE for the next byte ("next") or moves to ST_FINISH after the last byte ("last"). It also moves to ST_FINISH if its limit expires ("release-timeout"). ST_FINISH pulses done and returns to ST_IDLE ("retire").

Top module: `epp_cycle_engine`

## Requirements
- R1: A write to offset 3 or 4 runs byte cycles only when (ctrl_byte & 0x2F) == 0x04. The masked bits are direction = bit 5, select = bit 3, init = bit 2, autolf = bit 1 and strobe = bit 0; bits 7, 6 and 4 are ignored. Otherwise no strobe is raised, no byte is moved, and the timeout flag is unchanged.
- R2: A read from offset 3 or 4 runs byte cycles only when (ctrl_byte & 0x2F) == 0x24. Otherwise no strobe is raised and reg_rdata returns 0xFFFFFFFF.
- R3: Offset 3 uses pp_addr_stb and offset 4 uses pp_data_stb, and the two are never high together. Each strobe stays high until pp_wait is seen high and is then dropped. The next byte's strobe starts only after pp_wait is seen low. pp_write is 1 for writes and 0 for reads, and pp_dout carries the current write byte.
- R4: For offset 4, reg_size 0 moves 1 byte, reg_size 1 moves 2 bytes, and reg_size 2 or 3 moves 4 bytes. Bytes go lowest first, taken from reg_wdata[7:0], then [15:8], and so on. Offset 3 always moves exactly one byte.
- R5: Read data starts as all ones. Byte k from pp_din lands in reg_rdata[8k+7:8k], so bytes that are not obtained read as 0xFF.
- R6: A phase fails if pp_wait has not changed by the (tmo_limit+1)-th clock edge after the phase starts. A change seen on that very edge still counts as success. A failure sets the timeout flag, drops the strobe and skips all remaining bytes of the access.
- R7: The timeout flag is sticky: successful accesses leave it set. A read of offset 1 returns {24'h0, periph_lines[6:0], flag}.
- R8: A write to offset 1 with reg_wdata[0] = 1 clears the flag. A write with reg_wdata[0] = 0 leaves it unchanged.
- R9: reg_busy is high from the cycle after a request is accepted (request taken while reg_busy is low) until reg_done. reg_done is a single-cycle pulse that carries reg_rdata. Requests made while busy are ignored. Other offsets complete with reg_rdata = 0xFFFFFFFF and no strobe.
- R10: After reset, reg_busy, reg_done, both strobes and timeout_flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_req | input | 1 | Access request, taken while reg_busy is low |
| reg_wr | input | 1 | 1 = write access, 0 = read access |
| reg_addr | input | 3 | Register offset |
| reg_size | input | 2 | Data width code: 0 = byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| reg_wdata | input | 32 | Write data |
| ctrl_byte | input | 8 | Stored port control byte |
| periph_lines | input | 7 | Peripheral status lines for status bits 7..1 |
| tmo_limit | input | 8 | Wait limit per handshake phase, in cycles |
| pp_wait | input | 1 | Peripheral wait/acknowledge line |
| pp_din | input | 8 | Byte from the peripheral |
| reg_rdata | output | 32 | Read data, valid with reg_done |
| reg_busy | output | 1 | Access in progress |
| reg_done | output | 1 | Access complete, one-cycle pulse |
| pp_addr_stb | output | 1 | Address cycle strobe |
| pp_data_stb | output | 1 | Data cycle strobe |
| pp_write | output | 1 | Cycle direction, 1 = write |
| pp_dout | output | 8 | Byte to the peripheral |
| timeout_flag | output | 1 | Sticky timeout flag |

## Verification
Two events can fall on the same edge: the peripheral's wait line responding, and the phase timer reaching its limit. The bench provokes this by setting the peripheral model's response delay to exactly tmo_limit+1 cycles, so the acknowledge arrives on the same edge the limit is reached. The response must win: the byte completes and the flag stays clear. One cycle more of delay must instead abort the access, set the flag and stop after a single strobe. A second overlap is a new request arriving while an access is still running. The bench judges this by checking that only the first access's bytes reach the peripheral.

// File: rtl/epp_pkg.sv
package epp_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_STATUS   = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_EPP_ADDR = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_EPP_DATA = 3'd4;

    // control bits that take part in the cycle gate: dir, select, init, autolf, strobe
    localparam logic [7:0] GATE_MASK  = 8'h2F;
    localparam logic [7:0] GATE_WRITE = 8'h04;
    localparam logic [7:0] GATE_READ  = 8'h24;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STROBE,
        ST_RELEASE,
        ST_FINISH
    } epp_state_e;

endpackage

// File: rtl/epp_cycle_gate.sv
module epp_cycle_gate
    import epp_pkg::*;
(
    input  logic [7:0] ctrl,
    output logic       wr_ok,
    output logic       rd_ok
);

    logic [7:0] masked;

    always_comb begin
        masked = ctrl & GATE_MASK;
        wr_ok  = (masked == GATE_WRITE);
        rd_ok  = (masked == GATE_READ);
    end

    always_comb begin
        AST_GATE_EXCLUSIVE: assert (!(wr_ok && rd_ok)); // R1
    end

endmodule

// File: rtl/epp_wait_timer.sv
module epp_wait_timer #(
    parameter int LIMIT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               tick,
    input  logic [LIMIT_W-1:0] limit,
    output logic               expired
);

    logic [LIMIT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + LIMIT_W'(1);
        end
    end

    assign expired = (cnt_q == limit);

    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear && !expired) |=> (cnt_q == $past(cnt_q) + LIMIT_W'(1))); // R6

    AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/epp_timeout_flag.sv
module epp_timeout_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag_q); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q); // R7

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag_q); // R8

endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine
    import epp_pkg::*;
#(
    parameter int DATA_BYTES = 4,
    parameter int LIMIT_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_req,
    input  logic                    reg_wr,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [1:0]              reg_size,
    input  logic [8*DATA_BYTES-1:0] reg_wdata,
    input  logic [7:0]              ctrl_byte,
    input  logic [6:0]              periph_lines,
    input  logic [LIMIT_W-1:0]      tmo_limit,
    input  logic                    pp_wait,
    input  logic [7:0]              pp_din,
    output logic [8*DATA_BYTES-1:0] reg_rdata,
    output logic                    reg_busy,
    output logic                    reg_done,
    output logic                    pp_addr_stb,
    output logic                    pp_data_stb,
    output logic                    pp_write,
    output logic [7:0]              pp_dout,
    output logic                    timeout_flag
);

    localparam int DATA_W = 8 * DATA_BYTES;
    localparam int IDX_W  = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;

    epp_state_e state_q, state_d;

    logic              wr_q;
    logic              addr_cyc_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_idx_q;
    logic [IDX_W-1:0]  req_last_idx;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    logic gate_wr_ok, gate_rd_ok;
    logic is_epp, start_ok, accept;
    logic tmr_clr, tmr_tick, tmr_expired;
    logic fail, capture, advance, flag_clr;
    logic last_byte;

    epp_cycle_gate u_gate (
        .ctrl  (ctrl_byte),
        .wr_ok (gate_wr_ok),
        .rd_ok (gate_rd_ok)
    );

    epp_wait_timer #(.LIMIT_W(LIMIT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clr),
        .tick    (tmr_tick),
        .limit   (tmo_limit),
        .expired (tmr_expired)
    );

    epp_timeout_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (fail),
        .clr   (flag_clr),
        .flag  (timeout_flag)
    );

    // request decode
    always_comb begin
        accept   = (state_q == ST_IDLE) && reg_req;
        is_epp   = (reg_addr == OFS_EPP_ADDR) || (reg_addr == OFS_EPP_DATA);
        start_ok = is_epp && (reg_wr ? gate_wr_ok : gate_rd_ok);
        flag_clr = accept && reg_wr && (reg_addr == OFS_STATUS) && reg_wdata[0];
        if ((reg_addr == OFS_EPP_ADDR) || (reg_size == 2'd0)) begin
            req_last_idx = '0;
        end else if ((reg_size == 2'd1) && (DATA_BYTES >= 2)) begin
            req_last_idx = IDX_W'(1);
        end else begin
            req_last_idx = IDX_W'(DATA_BYTES - 1);
        end
        last_byte = (idx_q == last_idx_q);
    end

    // next state and per-cycle control
    always_comb begin
        state_d  = state_q;
        tmr_clr  = 1'b0;
        tmr_tick = 1'b0;
        fail     = 1'b0;
        capture  = 1'b0;
        advance  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                tmr_clr = 1'b1;
                if (reg_req) begin
                    state_d = start_ok ? ST_STROBE : ST_FINISH;
                end
            end
            ST_STROBE: begin
                if (pp_wait) begin
                    capture = !wr_q;
                    tmr_clr = 1'b1;
                    state_d = ST_RELEASE;
                end else if (tmr_expired) begin
                    fail    = 1'b1;
                    state_d = ST_FINISH;
                end else begin
                    tmr_tick = 1'b1;
                end
            end
            ST_RELEASE: begin
                if (!pp_wait) begin
                    tmr_clr = 1'b1;
                    if (last_byte) begin
                        state_d = ST_FINISH;
                    end else begin
                        advance = 1'b1;
                        state_d = ST_STROBE;
                    end
                end else if (tmr_expired) begin
                    fail    = 1'b1;
                    state_d = ST_FINISH;
                end else begin
                    tmr_tick = 1'b1;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // access context and data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q       <= 1'b0;
            addr_cyc_q <= 1'b0;
            idx_q      <= '0;
            last_idx_q <= '0;
            wdata_q    <= '0;
            rdata_q    <= '1;
        end else begin
            if (accept) begin
                wr_q       <= reg_wr;
                addr_cyc_q <= (reg_addr == OFS_EPP_ADDR);
                idx_q      <= '0;
                last_idx_q <= req_last_idx;
                wdata_q    <= reg_wdata;
                if (!reg_wr && (reg_addr == OFS_STATUS)) begin
                    rdata_q <= {{(DATA_W-8){1'b0}}, periph_lines, timeout_flag};
                end else begin
                    rdata_q <= '1;
                end
            end
            if (capture) begin
                rdata_q[{idx_q, 3'b000} +: 8] <= pp_din;
            end
            if (advance) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        pp_addr_stb = (state_q == ST_STROBE) && addr_cyc_q;
        pp_data_stb = (state_q == ST_STROBE) && !addr_cyc_q;
        pp_write    = wr_q;
        pp_dout     = wdata_q[{idx_q, 3'b000} +: 8];
        reg_busy    = (state_q != ST_IDLE);
        reg_done    = (state_q == ST_FINISH);
        reg_rdata   = rdata_q;
    end

    AST_GATED_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STROBE && $past(state_q) == ST_IDLE) |-> $past(start_ok)); // R1

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pp_addr_stb && pp_data_stb)); // R3

    AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pp_addr_stb || pp_data_stb) && !$past(pp_wait)) |-> (state_q == ST_FINISH)); // R3

    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> (!pp_addr_stb && !pp_data_stb && reg_done)); // R6

    AST_BUSY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (pp_addr_stb || pp_data_stb) |-> reg_busy); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_done |=> !reg_done); // R9

endmodule

// File: tb/tb_epp_cycle_engine.sv
module tb_epp_cycle_engine;
    import epp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    typedef struct packed {
        logic        wr;
        logic [2:0]  off;
        logic [1:0]  sz;
        logic [7:0]  ctrl;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic [2:0]  exp_n;
    } vec_t;

    // R1 R2 R4 R5 R9: gating, widths, byte placement and foreign offsets
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 3'd4, 2'd0, 8'h04, 32'h0000005A, 32'hFFFFFFFF, 3'd1},
        '{1'b1, 3'd4, 2'd1, 8'h14, 32'h00001234, 32'hFFFFFFFF, 3'd2},
        '{1'b1, 3'd4, 2'd2, 8'hC4, 32'hDEADBEEF, 32'hFFFFFFFF, 3'd4},
        '{1'b1, 3'd3, 2'd2, 8'h04, 32'h12345677, 32'hFFFFFFFF, 3'd1},
        '{1'b1, 3'd4, 2'd2, 8'h0C, 32'hCAFEF00D, 32'hFFFFFFFF, 3'd0},
        '{1'b1, 3'd4, 2'd0, 8'h24, 32'h00000033, 32'hFFFFFFFF, 3'd0},
        '{1'b0, 3'd4, 2'd3, 8'h24, 32'h00000000, 32'hA3A2A1A0, 3'd4},
        '{1'b0, 3'd4, 2'd1, 8'h34, 32'h00000000, 32'hFFFFA1A0, 3'd2},
        '{1'b0, 3'd3, 2'd0, 8'h24, 32'h00000000, 32'hFFFFFFA0, 3'd1},
        '{1'b0, 3'd4, 2'd2, 8'h04, 32'h00000000, 32'hFFFFFFFF, 3'd0},
        '{1'b0, 3'd4, 2'd0, 8'h25, 32'h00000000, 32'hFFFFFFFF, 3'd0},
        '{1'b0, 3'd5, 2'd0, 8'h24, 32'h00000000, 32'hFFFFFFFF, 3'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [1:0]  reg_size = '0;
    logic [31:0] reg_wdata = '0;
    logic [7:0]  ctrl_byte = 8'h0C;
    logic [6:0]  periph_lines = 7'h55;
    logic [7:0]  tmo_limit = 8'd20;
    logic        pp_wait = 1'b0;
    logic [7:0]  pp_din = '0;
    logic [31:0] reg_rdata;
    logic        reg_busy, reg_done, pp_addr_stb, pp_data_stb, pp_write, timeout_flag;
    logic [7:0]  pp_dout;

    epp_cycle_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
        .ctrl_byte(ctrl_byte), .periph_lines(periph_lines), .tmo_limit(tmo_limit),
        .pp_wait(pp_wait), .pp_din(pp_din), .reg_rdata(reg_rdata),
        .reg_busy(reg_busy), .reg_done(reg_done), .pp_addr_stb(pp_addr_stb),
        .pp_data_stb(pp_data_stb), .pp_write(pp_write), .pp_dout(pp_dout),
        .timeout_flag(timeout_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // peripheral model state
    int   dly_hi = 1, dly_lo = 1, pcnt = 0;
    bit   stuck_hi = 0, stuck_lo = 0, prev_stb = 0;
    int   n_rise = 0, n_wr = 0, n_rd = 0, n_addr = 0, n_data = 0, n_viol = 0;
    logic [7:0] wlog [8];
    logic [31:0] last_rd;
    logic        last_done;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic periph_clear();
        #1;
        pp_wait = 1'b0; pcnt = 0; stuck_hi = 0; stuck_lo = 0;
        dly_hi = 1; dly_lo = 1;
        n_rise = 0; n_wr = 0; n_rd = 0; n_addr = 0; n_data = 0;
        for (int k = 0; k < 8; k++) wlog[k] = 8'h00;
    endtask

    task automatic access(input logic wr, input logic [2:0] off, input logic [1:0] sz,
                          input logic [7:0] ctrl, input logic [31:0] wd);
        @(negedge clk);
        ctrl_byte = ctrl; reg_wr = wr; reg_addr = off; reg_size = sz; reg_wdata = wd;
        reg_req = 1'b1;
        @(negedge clk);
        reg_req = 1'b0;
        for (int i = 0; i < 3000 && !reg_done; i++) @(negedge clk);
        last_rd = reg_rdata;
        last_done = reg_done;
    endtask

    // peripheral responder, acting at falling edges
    initial begin
        forever begin
            @(negedge clk);
            begin
                bit stb;
                stb = pp_addr_stb || pp_data_stb;
                if (stb && !prev_stb) begin
                    n_rise++;
                    if (pp_wait) n_viol++;
                end
                if (stb && !pp_wait) begin
                    pcnt++;
                    if (!stuck_hi && pcnt >= dly_hi) begin
                        pcnt = 0;
                        pp_wait = 1'b1;
                        if (pp_addr_stb) n_addr++; else n_data++;
                        if (pp_write) begin
                            if (n_wr < 8) wlog[n_wr] = pp_dout;
                            n_wr++;
                        end else begin
                            pp_din = 8'hA0 + 8'(n_rd);
                            n_rd++;
                        end
                    end
                end else if (!stb && pp_wait) begin
                    pcnt++;
                    if (!stuck_lo && pcnt >= dly_lo) begin
                        pcnt = 0;
                        pp_wait = 1'b0;
                    end
                end else begin
                    pcnt = 0;
                end
                prev_stb = stb;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 busy after reset", 32'(reg_busy), 32'd0);
        check("R10 done after reset", 32'(reg_done), 32'd0);
        check("R10 strobes after reset", 32'({pp_addr_stb, pp_data_stb}), 32'd0);
        check("R10 flag after reset", 32'(timeout_flag), 32'd0);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            string tg;
            int bad;
            tg = $sformatf("R1/R2/R3/R4/R5/R9 vec%0d", v);
            periph_clear();
            access(VECS[v].wr, VECS[v].off, VECS[v].sz, VECS[v].ctrl, VECS[v].wdata);
            check({tg, " done"}, 32'(last_done), 32'd1);
            check({tg, " rdata"}, last_rd, VECS[v].exp_rd);
            check({tg, " bytes moved"}, VECS[v].wr ? n_wr : n_rd, 32'(VECS[v].exp_n));
            check({tg, " wrong direction"}, VECS[v].wr ? n_rd : n_wr, 32'd0);
            check({tg, " strobe kind"}, (VECS[v].off == 3'd3) ? n_addr : n_data,
                  32'(VECS[v].exp_n));
            bad = 0;
            if (VECS[v].wr)
                for (int k = 0; k < int'(VECS[v].exp_n); k++)
                    if (wlog[k] !== VECS[v].wdata[8*k +: 8]) bad++;
            check({tg, " byte order"}, bad, 32'd0);
            check({tg, " flag"}, 32'(timeout_flag), 32'd0);
        end
        check("R3 strobe raised while wait high", n_viol, 32'd0);

        // R3 slow handshake, four bytes
        periph_clear();
        dly_hi = 3; dly_lo = 2;
        access(1'b1, 3'd4, 2'd2, 8'h04, 32'h0BADCAFE);
        check("R3 slow write strobes", n_rise, 32'd4);
        check("R3 slow write byte0", 32'(wlog[0]), 32'hFE);
        check("R3 slow write byte3", 32'(wlog[3]), 32'h0B);
        check("R3 slow write violations", n_viol, 32'd0);

        // R6 boundary: response on the limit edge wins
        tmo_limit = 8'd4;
        periph_clear();
        dly_hi = 5;
        access(1'b1, 3'd4, 2'd0, 8'h04, 32'h00000042);
        check("R6 response at limit flag", 32'(timeout_flag), 32'd0);
        check("R6 response at limit bytes", n_wr, 32'd1);
        periph_clear();
        dly_hi = 6;
        access(1'b1, 3'd4, 2'd1, 8'h04, 32'h00004243);
        check("R6 one past limit flag", 32'(timeout_flag), 32'd1);
        check("R6 one past limit bytes", n_wr, 32'd0);
        check("R6 one past limit strobes", n_rise, 32'd1);

        // R7 status read and stickiness
        periph_clear();
        access(1'b0, 3'd1, 2'd0, 8'h04, 32'h0);
        check("R7 status with flag", last_rd, 32'h000000AB);
        periph_clear();
        access(1'b1, 3'd4, 2'd0, 8'h04, 32'h00000011);
        check("R7 flag survives good access", 32'(timeout_flag), 32'd1);
        check("R7 good access moved byte", n_wr, 32'd1);

        // R8 clear only with bit 0
        periph_clear();
        access(1'b1, 3'd1, 2'd0, 8'h04, 32'h000000FE);
        check("R8 write bit0 clear keeps flag", 32'(timeout_flag), 32'd1);
        access(1'b1, 3'd1, 2'd0, 8'h04, 32'h00000001);
        check("R8 write bit0 set clears flag", 32'(timeout_flag), 32'd0);
        periph_lines = 7'h2A;
        access(1'b0, 3'd1, 2'd0, 8'h04, 32'h0);
        check("R7 status without flag", last_rd, 32'h00000054);

        // R6 timeout in strobe phase, four-byte read
        tmo_limit = 8'd3;
        periph_clear();
        stuck_hi = 1;
        access(1'b0, 3'd4, 2'd2, 8'h24, 32'h0);
        check("R6 strobe phase abort rdata", last_rd, 32'hFFFFFFFF);
        check("R6 strobe phase abort strobes", n_rise, 32'd1);
        check("R6 strobe phase abort flag", 32'(timeout_flag), 32'd1);
        access(1'b1, 3'd1, 2'd0, 8'h04, 32'h00000001);

        // R6 timeout in release phase, four-byte read
        periph_clear();
        stuck_lo = 1;
        access(1'b0, 3'd4, 2'd2, 8'h24, 32'h0);
        check("R6 release phase abort rdata", last_rd, 32'hFFFFFFA0);
        check("R6 release phase abort strobes", n_rise, 32'd1);
        check("R6 release phase abort flag", 32'(timeout_flag), 32'd1);
        periph_clear();
        access(1'b1, 3'd1, 2'd0, 8'h04, 32'h00000001);
        check("R8 flag cleared again", 32'(timeout_flag), 32'd0);

        // R9 request while busy is ignored
        tmo_limit = 8'd20;
        periph_clear();
        dly_hi = 2;
        @(negedge clk);
        ctrl_byte = 8'h04; reg_wr = 1'b1; reg_addr = 3'd4; reg_size = 2'd2;
        reg_wdata = 32'h11223344; reg_req = 1'b1;
        @(negedge clk);
        check("R9 busy after accept", 32'(reg_busy), 32'd1);
        reg_size = 2'd0; reg_wdata = 32'h00000099;
        @(negedge clk);
        reg_req = 1'b0;
        for (int i = 0; i < 3000 && !reg_done; i++) @(negedge clk);
        check("R9 done seen", 32'(reg_done), 32'd1);
        @(negedge clk);
        check("R9 done single pulse", 32'(reg_done), 32'd0);
        check("R9 idle after done", 32'(reg_busy), 32'd0);
        repeat (6) @(negedge clk);
        check("R9 only first access moved", n_wr, 32'd4);
        check("R9 first byte kept", 32'(wlog[0]), 32'h44);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule